// File: doc/BRIEF.md
# Long-Frame SPI Bus Master

This block is a full-duplex serial peripheral bus master clocked from a 40 MHz system clock. One transfer moves a frame of 1 to 128 bits. A single 128-bit register holds the outgoing frame. As bits leave on MOSI, the bits arriving on MISO shift into the same register. When the frame completes, the register holds the received frame. The block applies no protocol of its own and only shifts the bits it is given.

The host sets these inputs:
- the frame length;
- clock polarity and phase;
- bit order;
- a 7-bit clock divider;
- an 8-bit slave-select mask;
- the transmit word.

A one-cycle `go` pulse then starts the transfer. `busy` stays high while the frame runs. A one-cycle `done` pulse marks the moment `rx_data` holds the received frame. All settings and the transmit word are captured at the accepted `go`, so the inputs may change freely while a transfer runs.

Top module: `spi_long_master`

## Requirements
- R1: The frame length is `cfg_len_m1 + 1` bits, from 1 (value 0) to 128 (value 127), and exactly that many SCLK cycles are produced.
- R2: Transmit and receive share one register. `rx_data` holds the received bits right-aligned in bits [N-1:0], and every bit at or above N reads zero.
- R3: `cfg_cpol` sets the SCLK idle level. With `cfg_cpha` = 0, MISO is sampled on the leading SCLK edge and MOSI changes on the trailing edge. With `cfg_cpha` = 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge. The idle level follows `cfg_cpol` while no transfer runs.
- R4: Bit i of `cfg_ss_mask` = 1 drives `ss_n[i]` low for the transfer. All `ss_n` lines are high whenever `busy` is low.
- R5: Every SCLK half period lasts `cfg_div + 1` system clock cycles, giving 40 MHz / (2·(DIV+1)), which spans 20 MHz down to about 156 kHz.
- R6: The selected `ss_n` lines fall one half period before the first SCLK edge. They rise one half period after the last SCLK edge.
- R7: For a `go` accepted at edge E0, `busy` is high from E0 onward. `done` is high for exactly one cycle, starting at edge E0 + (2N+1)·H + 1, where H = DIV+1. `busy` falls at that same edge.
- R8: A `go` that arrives while `busy` is high is ignored. It starts no second transfer and does not change the running one.
- R9: With `cfg_lsb_first` = 0, bit N-1 of the frame is sent first and the first received bit lands in bit N-1. With `cfg_lsb_first` = 1, bit 0 is sent first and the first received bit lands in bit 0.
- R10: All `cfg_*` inputs and `tx_data` are sampled only on an accepted `go`. Changing them during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, accepted only when idle |
| cfg_len_m1 | input | 7 | Frame length minus one |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | Sampling phase select |
| cfg_lsb_first | input | 1 | 1 = send bit 0 first |
| cfg_div | input | 7 | Half-period divider, half period = DIV+1 cycles |
| cfg_ss_mask | input | 8 | Slave-select lines to assert |
| tx_data | input | 128 | Frame to send, right-aligned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 128 | Received frame, right-aligned, upper bits zero |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out, low when idle |
| miso | input | 1 | Serial data in |
| ss_n | output | 8 | Active-low slave selects |

## Verification
The bench checks three kinds of internal fault at the ports.
- A wrong edge counter or divider shows up as a `done` pulse at the wrong cycle. It also shows up as a first-edge or last-edge gap on SCLK that differs from DIV+1. Both are visible within the same frame.
- A wrong sample phase, bit order or insertion point in the shared register shows as a corrupted frame. Either the word the bench-side slave captures from MOSI is wrong, or `rx_data` is wrong when `done` rises.
- A sequencer that accepts `go` while busy produces an extra or early `done`, or alters the running frame. This appears no later than the end of that frame.

// File: rtl/spi_lf_pkg.sv
package spi_lf_pkg;

    localparam int SPI_DATA_W = 128;
    localparam int SPI_DIV_W  = 7;
    localparam int SPI_SS_N   = 8;
    localparam int SPI_LEN_W  = $clog2(SPI_DATA_W);
    localparam int SPI_EDGE_W = SPI_LEN_W + 2;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_LEAD  = 2'd1,
        SEQ_SHIFT = 2'd2,
        SEQ_FIN   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [SPI_LEN_W-1:0] len_m1;
        logic                 cpol;
        logic                 cpha;
        logic                 lsb_first;
        logic [SPI_DIV_W-1:0] div;
        logic [SPI_SS_N-1:0]  ss_mask;
    } xfer_cfg_t;

    // Ones in bits [len_m1:0], zero above.
    function automatic logic [SPI_DATA_W-1:0] frame_mask(input logic [SPI_LEN_W-1:0] len_m1);
        logic [SPI_DATA_W-1:0] all_ones;
        all_ones = '1;
        return all_ones >> (SPI_DATA_W - 1 - int'(len_m1));
    endfunction

    // Number of SCLK edges in a frame: 2 * (len_m1 + 1).
    function automatic logic [SPI_EDGE_W-1:0] edge_total(input logic [SPI_LEN_W-1:0] len_m1);
        logic [SPI_EDGE_W-1:0] nbits;
        nbits = {2'b00, len_m1} + SPI_EDGE_W'(1);
        return nbits << 1;
    endfunction

endpackage

// File: rtl/spi_lf_tick.sv
module spi_lf_tick #(
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clr,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DW'(1);
        end
    end
endmodule

// File: rtl/spi_lf_shreg.sv
module spi_lf_shreg #(
    parameter int W = 128,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [W-1:0]  load_val,
    input  logic          shift,
    input  logic          in_bit,
    input  logic          lsb_first,
    input  logic [IW-1:0] len_m1,
    output logic [W-1:0]  q,
    output logic          out_bit
);
    logic [W-1:0] q_r;
    logic [W-1:0] toward_msb;
    logic [W-1:0] toward_lsb;

    // MSB-first frames leave from bit len_m1 and fill from bit 0.
    // LSB-first frames leave from bit 0 and fill at bit len_m1.
    always_comb begin
        toward_msb = {q_r[W-2:0], in_bit};
        toward_lsb = q_r >> 1;
        toward_lsb[len_m1] = in_bit;
    end

    assign out_bit = lsb_first ? q_r[0] : q_r[len_m1];
    assign q       = q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (load) begin
            q_r <= load_val;
        end else if (shift) begin
            q_r <= lsb_first ? toward_lsb : toward_msb;
        end
    end
endmodule

// File: rtl/spi_lf_seq.sv
module spi_lf_seq
    import spi_lf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  xfer_cfg_t           cfg_in,
    input  logic                tick,
    input  logic                miso,
    output xfer_cfg_t           cfg_q,
    output logic                busy,
    output logic                done,
    output logic                sclk,
    output logic [SPI_SS_N-1:0] ss_n,
    output logic                load,
    output logic                shift_en,
    output logic                shift_bit,
    output logic                run,
    output logic                fin
);
    seq_state_e            state_q;
    xfer_cfg_t             cfg_r;
    logic [SPI_EDGE_W-1:0] tcnt_q;
    logic [SPI_EDGE_W-1:0] tnext;
    logic                  sclk_q;
    logic                  pend_q;
    logic                  rxb_q;
    logic                  done_q;
    logic [SPI_SS_N-1:0]   ss_q;

    assign tnext     = tcnt_q + SPI_EDGE_W'(1);
    assign cfg_q     = cfg_r;
    assign busy      = (state_q != SEQ_IDLE);
    assign done      = done_q;
    assign sclk      = sclk_q;
    assign ss_n      = ss_q;
    assign load      = (state_q == SEQ_IDLE) && go;
    assign run       = (state_q == SEQ_LEAD) || (state_q == SEQ_SHIFT);
    assign fin       = (state_q == SEQ_FIN);
    assign shift_en  = (state_q == SEQ_SHIFT) && tick && pend_q;
    assign shift_bit = rxb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cfg_r   <= '0;
            tcnt_q  <= '0;
            sclk_q  <= 1'b0;
            pend_q  <= 1'b0;
            rxb_q   <= 1'b0;
            done_q  <= 1'b0;
            ss_q    <= '1;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    sclk_q <= cfg_in.cpol;
                    if (go) begin
                        cfg_r   <= cfg_in;
                        ss_q    <= ~cfg_in.ss_mask;
                        tcnt_q  <= '0;
                        pend_q  <= 1'b0;
                        state_q <= SEQ_LEAD;
                    end
                end
                SEQ_LEAD: begin
                    if (tick) begin
                        // first edge is always a leading edge
                        sclk_q  <= ~sclk_q;
                        tcnt_q  <= SPI_EDGE_W'(1);
                        state_q <= SEQ_SHIFT;
                        if (!cfg_r.cpha) begin
                            rxb_q  <= miso;
                            pend_q <= 1'b1;
                        end
                    end
                end
                SEQ_SHIFT: begin
                    if (tick) begin
                        pend_q <= 1'b0;
                        if (tcnt_q == edge_total(cfg_r.len_m1)) begin
                            ss_q    <= '1;
                            state_q <= SEQ_FIN;
                        end else begin
                            sclk_q <= ~sclk_q;
                            tcnt_q <= tnext;
                            // odd edge count = leading edge
                            if (tnext[0] ^ cfg_r.cpha) begin
                                rxb_q  <= miso;
                                pend_q <= 1'b1;
                            end
                        end
                    end
                end
                SEQ_FIN: begin
                    done_q  <= 1'b1;
                    state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_long_master.sv
module spi_long_master
    import spi_lf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [SPI_LEN_W-1:0]  cfg_len_m1,
    input  logic                  cfg_cpol,
    input  logic                  cfg_cpha,
    input  logic                  cfg_lsb_first,
    input  logic [SPI_DIV_W-1:0]  cfg_div,
    input  logic [SPI_SS_N-1:0]   cfg_ss_mask,
    input  logic [SPI_DATA_W-1:0] tx_data,
    output logic                  busy,
    output logic                  done,
    output logic [SPI_DATA_W-1:0] rx_data,
    output logic                  sclk,
    output logic                  mosi,
    input  logic                  miso,
    output logic [SPI_SS_N-1:0]   ss_n
);
    xfer_cfg_t             cfg_in;
    xfer_cfg_t             cfg_q;
    logic                  tick;
    logic                  load;
    logic                  shift_en;
    logic                  shift_bit;
    logic                  run;
    logic                  fin;
    logic                  out_bit;
    logic [SPI_DATA_W-1:0] sr_q;
    logic [SPI_DATA_W-1:0] rx_q;

    always_comb begin
        cfg_in.len_m1    = cfg_len_m1;
        cfg_in.cpol      = cfg_cpol;
        cfg_in.cpha      = cfg_cpha;
        cfg_in.lsb_first = cfg_lsb_first;
        cfg_in.div       = cfg_div;
        cfg_in.ss_mask   = cfg_ss_mask;
    end

    spi_lf_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .cfg_in    (cfg_in),
        .tick      (tick),
        .miso      (miso),
        .cfg_q     (cfg_q),
        .busy      (busy),
        .done      (done),
        .sclk      (sclk),
        .ss_n      (ss_n),
        .load      (load),
        .shift_en  (shift_en),
        .shift_bit (shift_bit),
        .run       (run),
        .fin       (fin)
    );

    spi_lf_tick #(.DW(SPI_DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .clr  (load),
        .div  (cfg_q.div),
        .tick (tick)
    );

    spi_lf_shreg #(.W(SPI_DATA_W)) u_shreg (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_val  (tx_data & frame_mask(cfg_len_m1)),
        .shift     (shift_en),
        .in_bit    (shift_bit),
        .lsb_first (cfg_q.lsb_first),
        .len_m1    (cfg_q.len_m1),
        .q         (sr_q),
        .out_bit   (out_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
        end else if (fin) begin
            rx_q <= sr_q & frame_mask(cfg_q.len_m1);
        end
    end

    assign rx_data = rx_q;
    assign mosi    = busy & out_bit;
endmodule

// File: rtl/spi_lf_checker.sv
module spi_lf_checker (
    input logic       clk,
    input logic       rst,
    input logic       go,
    input logic       busy,
    input logic       done,
    input logic       sclk,
    input logic       cfg_cpol,
    input logic [7:0] ss_n
);
    // R4: no slave selected while idle
    a_r4_ss_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (&ss_n));

    // R4, R6: during a transfer ss_n may only change by releasing all lines
    a_r4_ss_release_only: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$stable(ss_n)) |-> (&ss_n));

    // R7: done lasts one cycle
    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: done coincides with the end of busy
    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R7, R8: a transfer only begins from a go pulse
    a_r7_busy_needs_go: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(go));

    // R3: idle SCLK level follows the polarity setting
    a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy) && $past(!rst)) |-> (sclk == $past(cfg_cpol)));
endmodule

bind spi_long_master spi_lf_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .busy     (busy),
    .done     (done),
    .sclk     (sclk),
    .cfg_cpol (cfg_cpol),
    .ss_n     (ss_n)
);

// File: tb/spi_long_master_tb_top.sv
module spi_long_master_tb_top;
    localparam int CLK_PERIOD = 25;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         go = 1'b0;
    logic [6:0]   cfg_len_m1 = '0;
    logic         cfg_cpol = 1'b0;
    logic         cfg_cpha = 1'b0;
    logic         cfg_lsb_first = 1'b0;
    logic [6:0]   cfg_div = '0;
    logic [7:0]   cfg_ss_mask = '0;
    logic [127:0] tx_data = '0;
    logic         busy;
    logic         done;
    logic [127:0] rx_data;
    logic         sclk;
    logic         mosi;
    logic         miso = 1'b0;
    logic [7:0]   ss_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_long_master dut_i (
        .clk(clk), .rst(rst), .go(go), .cfg_len_m1(cfg_len_m1), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .cfg_div(cfg_div),
        .cfg_ss_mask(cfg_ss_mask), .tx_data(tx_data), .busy(busy), .done(done),
        .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- slave model ----------------
    int           s_n = 1;
    bit           s_cpol, s_cpha, s_lsb;
    logic [127:0] s_resp;
    logic [127:0] cap;
    int           s_idx, cap_cnt;
    int           t_ssf, t_ssr, t_first, t_last;
    bit           first_seen;
    logic [7:0]   ss_seen;
    logic         sel_any;
    assign sel_any = ~&ss_n;

    function automatic int bpos(input int k);
        return s_lsb ? k : (s_n - 1 - k);
    endfunction

    initial begin
        logic prev_sel;
        logic prev_sclk;
        prev_sel = 1'b0;
        prev_sclk = 1'b0;
        forever begin
            @(sel_any or sclk);
            #1;
            if (sel_any && !prev_sel) begin
                ss_seen = ss_n;
                t_ssf = cyc;
                if (!s_cpha) begin
                    miso = s_resp[bpos(0)];
                    s_idx = 1;
                end
            end else if (!sel_any && prev_sel) begin
                t_ssr = cyc;
            end else if (sel_any && (sclk != prev_sclk)) begin
                if (!first_seen) begin
                    t_first = cyc;
                    first_seen = 1'b1;
                end
                t_last = cyc;
                if ((sclk != s_cpol) ^ s_cpha) begin
                    if (cap_cnt < s_n) cap[bpos(cap_cnt)] = mosi;
                    cap_cnt++;
                end else if (s_idx < s_n) begin
                    miso = s_resp[bpos(s_idx)];
                    s_idx++;
                end
            end
            prev_sel = sel_any;
            prev_sclk = sclk;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [127:0] rx_exp;
        logic [127:0] tx_exp;
        logic [7:0]   ss_exp;
        int           lat;
        int           h;
        int           t_go;
    } sb_item_t;

    sb_item_t sb_q[$];

    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R8 unexpected done", 128'(done), 128'd0);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                chk(rx_data == it.rx_exp, "R2/R9 rx_data", rx_data, it.rx_exp);
                chk(cap == it.tx_exp, "R1/R3/R9 mosi frame", cap, it.tx_exp);
                chk((cyc - it.t_go) == it.lat, "R7/R5 done latency", 128'(cyc - it.t_go), 128'(it.lat));
                chk(ss_seen == it.ss_exp, "R4 ss_n pattern", 128'(ss_seen), 128'(it.ss_exp));
                chk((t_first - t_ssf) == it.h, "R6 lead gap", 128'(t_first - t_ssf), 128'(it.h));
                chk((t_ssr - t_last) == it.h, "R6 lag gap", 128'(t_ssr - t_last), 128'(it.h));
                chk((&ss_n) && !busy, "R7 idle after done", 128'({busy, ss_n}), 128'({1'b0, 8'hFF}));
            end
        end
    end

    task automatic run_xfer(input int nbits, input bit cpol, input bit cpha, input bit lsb,
                            input int div, input logic [7:0] mask,
                            input logic [127:0] tx, input logic [127:0] resp, input bit poke);
        sb_item_t it;
        logic [127:0] m;
        m = (nbits == 128) ? '1 : ((128'd1 << nbits) - 128'd1);
        @(negedge clk);
        cfg_len_m1 = 7'(nbits - 1);
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb;
        cfg_div = 7'(div); cfg_ss_mask = mask; tx_data = tx;
        s_n = nbits; s_cpol = cpol; s_cpha = cpha; s_lsb = lsb; s_resp = resp;
        s_idx = 0; cap = '0; cap_cnt = 0; first_seen = 1'b0;
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        it.rx_exp = resp & m;
        it.tx_exp = tx & m;
        it.ss_exp = ~mask;
        it.h = div + 1;
        it.lat = (2 * nbits + 1) * (div + 1) + 1;
        it.t_go = cyc;
        sb_q.push_back(it);
        if (poke) begin
            // R8, R10: a new go and new settings while busy must change nothing
            repeat (3) @(negedge clk);
            cfg_len_m1 = 7'd3; cfg_cpol = ~cpol; cfg_cpha = ~cpha; cfg_lsb_first = ~lsb;
            cfg_div = 7'd0; cfg_ss_mask = 8'hFF; tx_data = ~tx;
            go = 1'b1;
            @(negedge clk);
            go = 1'b0;
        end
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R7 reset busy/done", 128'({busy, done}), 128'd0);
        chk(ss_n == 8'hFF, "R4 reset ss_n", 128'(ss_n), 128'hFF);
        chk(sclk == 1'b0 && mosi == 1'b0, "R3 reset sclk/mosi", 128'({sclk, mosi}), 128'd0);
        chk(rx_data == '0, "R2 reset rx_data", rx_data, 128'd0);

        // R1 R3 R9: 8-bit mode 0, MSB first, fastest clock
        run_xfer(8, 1'b0, 1'b0, 1'b0, 0, 8'h01, 128'hA5, 128'h3C, 1'b0);
        // R1: full 128-bit frame, mode 3
        run_xfer(128, 1'b1, 1'b1, 1'b0, 1, 8'h80,
                 128'hDEADBEEF_01234567_89ABCDEF_F0E1D2C3,
                 128'h13579BDF_2468ACE0_55AA33CC_0F1E2D3C, 1'b0);
        // R1 R9: single bit, mode 1, LSB first
        run_xfer(1, 1'b0, 1'b1, 1'b1, 2, 8'h81, 128'h1, 128'h1, 1'b0);
        // R2: short frame with upper tx bits set, mode 2, LSB first
        run_xfer(13, 1'b1, 1'b0, 1'b1, 3, 8'h5A, '1, 128'h1B2D, 1'b0);
        // R5: slowest divider
        run_xfer(32, 1'b0, 1'b0, 1'b1, 127, 8'h10, 128'hCAFEF00D, 128'h8BADF00D, 1'b0);
        // R8 R10: go and setting changes during a transfer
        run_xfer(16, 1'b0, 1'b1, 1'b0, 2, 8'h24, 128'h6B3C, 128'h9D21, 1'b1);
        repeat (20) @(negedge clk);
        chk(!busy, "R8 no extra transfer", 128'(busy), 128'd0);
        // R3: idle level follows polarity
        cfg_cpol = 1'b1;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1, "R3 idle level", 128'(sclk), 128'd1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule